// File: doc/BRIEF.md
# Byte-Accessed Free-Running Timer

This block is a 16-bit up-counter that serves as a general time base for a processor whose register bus is eight bits wide. Software reaches the count one byte at a time. The block keeps each 16-bit access atomic by pairing the two bytes through holding registers. For a read, fetching the low byte freezes the matching high byte. For a write, the low byte is staged and the whole word is committed together with the high byte.

The counter advances on each clock where a tick-enable input is high. That input stands in for a slower timer clock and is assumed to be already synchronous to the bus clock. Two interrupt pulses are taken from the count. One fires every 4096 ticks, when the low twelve bits roll over. The other fires every 65536 ticks, when the whole counter wraps.

Top module: `frt_byte_timer`

## Requirements
- R1: After reset the count is 0x0000, both byte offsets read 0x00, and both interrupt outputs are low.
- R2: On each clock edge where `tick_en` is high and no high-byte write happens, the count rises by exactly one. With `tick_en` low and no high-byte write, the count holds its value.
- R3: A read at offset 0 returns the live low byte of the count. At the same clock edge, it copies the live high byte into a read-holding register.
- R4: A read at offset 1 returns the read-holding register. Later ticks do not change what it returns until the next read at offset 0.
- R5: A write at offset 0 only stages its byte. The count is unchanged by it and keeps counting.
- R6: A write at offset 1 loads the count with {written byte, staged low byte} at that clock edge. This load takes precedence over a tick in the same cycle.
- R7: `irq_period` is a one-cycle pulse. It is high in the cycle after a tick moves bits [11:0] of the count from 0xFFF to 0x000.
- R8: `irq_wrap` is a one-cycle pulse. It is high in the cycle after a tick moves the count from 0xFFFF to 0x0000, and `irq_period` is high in that same cycle.
- R9: A read at any offset other than 0 or 1 (offsets 2 and 3 with the default 2-bit address) returns 0x00.
- R10: Loading the count through a high-byte write never raises either interrupt, even when the loaded value has bits [11:0] equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count-advance enable, one bus clock wide per tick |
| bus_addr | input | ADDR_W | Register offset: 0 is the low byte, 1 is the high byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| irq_period | output | 1 | Pulse every 4096 ticks |
| irq_wrap | output | 1 | Pulse on counter wrap |

## Verification
A tick and a bus access can land on the same clock edge, and this is where the block is most likely to go wrong. The bench provokes this in two ways. In the first, it asserts `tick_en` together with a high-byte write, and expects the loaded word with no increment. In the second, it asserts `tick_en` together with a low-byte read while the count sits at 0x00FF. The low byte returned must be 0xFF, and the high byte read next must be 0x00, not 0x01. The two bytes therefore join into the pre-carry value, and a direct read of the count afterwards shows 0x0100 plus any further ticks.

// File: rtl/frt_byte_timer.sv
module frt_byte_timer #(
  parameter int ADDR_W   = 2,
  parameter int PERIOD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_period,
  output logic              irq_wrap
);
  localparam logic [ADDR_W-1:0] OFS_LO = '0;
  localparam logic [ADDR_W-1:0] OFS_HI = ADDR_W'(1);

  logic [15:0] cnt;
  logic [7:0]  rd_hold;
  logic [7:0]  wr_hold;

  wire sel_lo      = (bus_addr == OFS_LO);
  wire sel_hi      = (bus_addr == OFS_HI);
  wire load_hi     = bus_wr & sel_hi;
  wire adv         = tick_en & ~load_hi;
  wire period_roll = adv & (&cnt[PERIOD_W-1:0]);
  wire wrap_roll   = adv & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      rd_hold    <= '0;
      wr_hold    <= '0;
      irq_period <= 1'b0;
      irq_wrap   <= 1'b0;
    end else begin
      if (load_hi)         cnt <= {bus_wdata, wr_hold};
      else if (adv)        cnt <= cnt + 16'd1;
      if (bus_rd & sel_lo) rd_hold <= cnt[15:8];
      if (bus_wr & sel_lo) wr_hold <= bus_wdata;
      irq_period <= period_roll;
      irq_wrap   <= wrap_roll;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (sel_lo)      bus_rdata = cnt[7:0];
    else if (sel_hi) bus_rdata = rd_hold;
  end
endmodule

// File: rtl/frt_byte_timer_chk.sv
module frt_byte_timer_chk #(
  parameter int ADDR_W   = 2,
  parameter int PERIOD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              irq_period,
  input logic              irq_wrap,
  input logic [15:0]       cnt,
  input logic [7:0]        wr_hold
);
  wire hi_wr = bus_wr && (bus_addr == ADDR_W'(1));
  wire lo_rd = bus_rd && (bus_addr == ADDR_W'(0));
  wire hi_rd = bus_rd && (bus_addr == ADDR_W'(1));

  always_comb if (!rst_n) a_r1_reset_clear: assert (cnt == 16'h0 && !irq_period && !irq_wrap);

  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tick_en && !hi_wr)) |-> cnt == $past(cnt) + 16'd1);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!tick_en && !hi_wr)) |-> $stable(cnt));

  a_r4_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lo_rd) && hi_rd) |-> bus_rdata == $past(cnt[15:8]));

  a_r6_load_word: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hi_wr)) |-> cnt == {$past(bus_wdata), $past(wr_hold)});

  a_r7_period_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |-> cnt[PERIOD_W-1:0] == '0);

  a_r7_period_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |=> !irq_period);

  a_r8_wrap_pair: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wrap |-> (irq_period && cnt == 16'h0));

  a_r10_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hi_wr)) |-> (!irq_period && !irq_wrap));
endmodule

bind frt_byte_timer frt_byte_timer_chk #(.ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_period(irq_period), .irq_wrap(irq_wrap), .cnt(cnt), .wr_hold(wr_hold)
);

// File: tb/frt_byte_timer_tb.sv
`timescale 1ns/1ps
module frt_byte_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_period, irq_wrap;
  logic [7:0] last_rd;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  frt_byte_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_period(irq_period), .irq_wrap(irq_wrap)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic [1:0] a,
                      input logic [7:0] d, input logic tk);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; tick_en = tk;
    #1 last_rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] lo;
    step(1, 0, 2'd0, 8'h00, 0); lo = last_rd;
    step(1, 0, 2'd1, 8'h00, 0);
    v = {last_rd, lo};
  endtask

  task automatic load16(input logic [15:0] v);
    step(0, 1, 2'd0, v[7:0], 0);
    step(0, 1, 2'd1, v[15:8], 0);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 irq_period", irq_period, 0);
    check("R1 irq_wrap", irq_wrap, 0);
    read16(v);
    check("R1 count", v, 16'h0000);
  endtask

  task automatic t_tick();
    logic [15:0] v;
    repeat (3) step(0, 0, 2'd0, 8'h00, 0);
    read16(v);
    check("R2 hold without tick", v, 16'h0000);
    repeat (5) step(0, 0, 2'd0, 8'h00, 1);
    read16(v);
    check("R2 five ticks", v, 16'h0005);
  endtask

  task automatic t_write();
    logic [15:0] v;
    step(0, 1, 2'd0, 8'h34, 0);
    read16(v);
    check("R5 low write staged only", v, 16'h0005);
    step(0, 0, 2'd0, 8'h00, 1);
    step(0, 1, 2'd1, 8'h12, 0);
    read16(v);
    check("R6 word load", v, 16'h1234);
    step(0, 1, 2'd0, 8'hAA, 0);
    step(0, 1, 2'd1, 8'h77, 1);
    read16(v);
    check("R6 load beats tick", v, 16'h77AA);
  endtask

  task automatic t_snapshot();
    logic [15:0] v;
    logic [7:0] lo;
    load16(16'h00FF);
    step(1, 0, 2'd0, 8'h00, 1); lo = last_rd;
    check("R3 live low byte", lo, 8'hFF);
    step(1, 0, 2'd1, 8'h00, 0);
    check("R4 pre-carry high byte", last_rd, 8'h00);
    repeat (10) step(0, 0, 2'd0, 8'h00, 1);
    step(1, 0, 2'd1, 8'h00, 0);
    check("R4 hold survives ticks", last_rd, 8'h00);
    read16(v);
    check("R3 fresh snapshot", v, 16'h010A);
  endtask

  task automatic t_period();
    logic [15:0] v;
    load16(16'h0FFD);
    step(0, 0, 2'd0, 8'h00, 1);
    check("R7 no pulse at FFE", irq_period, 0);
    step(0, 0, 2'd0, 8'h00, 1);
    check("R7 no pulse at FFF", irq_period, 0);
    step(0, 0, 2'd0, 8'h00, 1);
    check("R7 pulse at rollover", irq_period, 1);
    check("R8 no wrap at 0x1000", irq_wrap, 0);
    step(0, 0, 2'd0, 8'h00, 0);
    check("R7 pulse one cycle", irq_period, 0);
    read16(v);
    check("R7 count after rollover", v, 16'h1000);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    load16(16'hFFFF);
    check("R10 no irq on load", irq_period | irq_wrap, 0);
    step(0, 0, 2'd0, 8'h00, 1);
    check("R8 wrap pulse", irq_wrap, 1);
    check("R8 period with wrap", irq_period, 1);
    step(0, 0, 2'd0, 8'h00, 0);
    check("R8 wrap one cycle", irq_wrap, 0);
    read16(v);
    check("R8 count wrapped", v, 16'h0000);
  endtask

  task automatic t_load_quiet();
    load16(16'h1FFF);
    step(0, 1, 2'd0, 8'h00, 0);
    step(0, 1, 2'd1, 8'h20, 1);
    check("R10 load to x000 quiet", irq_period, 0);
    check("R10 wrap quiet", irq_wrap, 0);
  endtask

  task automatic t_unmapped();
    step(1, 0, 2'd2, 8'h00, 0);
    check("R9 offset 2", last_rd, 8'h00);
    step(1, 0, 2'd3, 8'h00, 0);
    check("R9 offset 3", last_rd, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_reset();
    t_tick();
    t_write();
    t_snapshot();
    t_period();
    t_wrap();
    t_load_quiet();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule